// File: doc/BRIEF.md
# Bit-Band Alias Access Bridge

This bridge sits on the path from a single bus master to a memory or peripheral port. Two alias windows each stand for a 1 MB bit-band region. In a window, every 4-byte alias word maps to one bit of that region. The bridge converts an access to an alias word into a single-bit operation on the matching 32-bit word of the region. Any other address goes through unchanged.

An alias read fetches the target word and returns the chosen bit alone, in bit 0 of the read data. An alias write runs a read-modify-write of the target word. It changes only the chosen bit, using bit 0 of the write data. A lock output stays high from the issue of the read phase until the write phase is accepted, so that a downstream arbiter keeps the two phases together. The upstream completion is given only after the write has been accepted.

Both sides use valid/ready requests. A request carries an address, a write flag, a size code (0 byte, 1 halfword, 2 word) and write data. On the downstream side, read data is valid in the cycle of the handshake. On the upstream side, the bridge raises `up_ready` for one cycle as the completion, and read data is valid in that cycle.

Top module: `bitband_bridge`

## Requirements
- R1: An address in alias window k (window 0 at 0x22000000, window 1 at 0x42000000, each 32 MB) with offset O addresses word (region base k + (O >> 7) * 4) and bit ((O >> 2) & 31) of that word. Address bits [1:0] play no part, and the downstream access is word sized (size code 2).
- R2: An alias read completes with the target bit in up_rdata[0], and all other up_rdata bits are zero.
- R3: An alias write sets the target bit when up_wdata[0] is 1 and clears it when up_wdata[0] is 0. Every other bit of the target word keeps its value.
- R4: The size code of an alias access (byte, halfword or word) has no effect on the selected word, the selected bit or the result.
- R5: An alias write makes exactly two downstream transfers to the same word, first a read and then a write. dn_lock is high for both and low again once the write has been accepted. up_ready is given only after the write.
- R6: Any address outside both alias windows, including addresses inside the bit-band regions (0x20000000 and 0x40000000, each 1 MB) and in the gaps, goes downstream as one transfer with the address, write flag, size and write data unchanged. Its read data comes back unchanged.
- R7: Each request gets exactly one completion. up_ready is a one-cycle pulse, and a write completes with zero read data. A stalled downstream request keeps its valid, address, write flag and write data stable.
- R8: While reset is held, up_ready, dn_valid and dn_lock are low.
- R9: Accesses through alias window 1 act on region 1 (0x40000000), and accesses through window 0 act on region 0 (0x20000000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| up_valid | input | 1 | Upstream request valid, held until up_ready |
| up_ready | output | 1 | One-cycle completion of the upstream request |
| up_addr | input | 32 | Upstream byte address |
| up_write | input | 1 | Upstream write flag |
| up_size | input | 2 | Upstream size code (0 byte, 1 halfword, 2 word) |
| up_wdata | input | 32 | Upstream write data |
| up_rdata | output | 32 | Upstream read data, valid with up_ready |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream accept, with read data in the same cycle |
| dn_addr | output | 32 | Downstream byte address |
| dn_write | output | 1 | Downstream write flag |
| dn_size | output | 2 | Downstream size code |
| dn_wdata | output | 32 | Downstream write data |
| dn_rdata | input | 32 | Downstream read data, valid on the handshake |
| dn_lock | output | 1 | Held high across both phases of an alias read-modify-write |

## Verification
The assertions assume that the master holds `up_valid` and all request fields steady from the cycle it raises the request until it sees `up_ready`. They also assume that the downstream port returns read data in the cycle of its handshake and that the arbiter behind `dn_lock` lets no other master in while the lock is high. The bench driver keeps every request steady until its completion and drops valid before the bridge can capture again. Its memory model answers only in handshake cycles and stalls `dn_ready` one cycle in every four, so that the stable-request and lock-hold properties see real stalls.

// File: rtl/bb_pkg.sv
package bb_pkg;
  localparam int ADDR_W_DEF   = 32;
  localparam int DATA_W_DEF   = 32;
  localparam int NUM_WIN_DEF  = 2;
  localparam int REGION_LOG2_DEF = 20;

  // index 0: first region / window, index 1: second
  localparam logic [1:0][31:0] REGION_BASE_DEF = {32'h4000_0000, 32'h2000_0000};
  localparam logic [1:0][31:0] ALIAS_BASE_DEF  = {32'h4200_0000, 32'h2200_0000};

  localparam logic [1:0] SIZE_WORD = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PASS,
    ST_ALRD,
    ST_RMW_RD,
    ST_RMW_WR,
    ST_RESP
  } seq_state_e;
endpackage

// File: rtl/bb_rst_sync.sv
module bb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/bb_decode.sv
module bb_decode #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int NUM_WIN     = 2,
  parameter int REGION_LOG2 = 20,
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] REGION_BASE = bb_pkg::REGION_BASE_DEF,
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] ALIAS_BASE  = bb_pkg::ALIAS_BASE_DEF
) (
  input  logic [ADDR_W-1:0]         addr,
  output logic                      alias_hit,
  output logic [ADDR_W-1:0]         word_addr,
  output logic [$clog2(DATA_W)-1:0] bit_idx
);
  localparam int BIT_W      = $clog2(DATA_W);
  localparam int BYTE_SH    = $clog2(DATA_W / 8);
  localparam int ALIAS_LOG2 = REGION_LOG2 + BIT_W;
  localparam int WORD_SH    = BIT_W + 2;

  logic [NUM_WIN-1:0]                 hit;
  logic [NUM_WIN-1:0][ADDR_W-1:0]     waddr;

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
    logic [ADDR_W-1:0] off;
    assign off      = {{(ADDR_W-ALIAS_LOG2){1'b0}}, addr[ALIAS_LOG2-1:0]};
    assign hit[k]   = (addr[ADDR_W-1:ALIAS_LOG2] == ALIAS_BASE[k][ADDR_W-1:ALIAS_LOG2]);
    assign waddr[k] = REGION_BASE[k] + ((off >> WORD_SH) << BYTE_SH);
  end

  always_comb begin
    alias_hit = 1'b0;
    word_addr = addr;
    for (int k = 0; k < NUM_WIN; k++) begin
      if (hit[k]) begin
        alias_hit = 1'b1;
        word_addr = waddr[k];
      end
    end
  end

  assign bit_idx = addr[WORD_SH-1:2];

  // R1
  always_comb begin
    if (!$isunknown(addr)) begin
      win_excl_chk: assert ($onehot0(hit));
    end
  end
endmodule

// File: rtl/bb_seq.sv
module bb_seq
  import bb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      up_valid,
  input  logic [ADDR_W-1:0]         up_addr,
  input  logic                      up_write,
  input  logic [1:0]                up_size,
  input  logic [DATA_W-1:0]         up_wdata,
  input  logic                      alias_hit,
  input  logic [ADDR_W-1:0]         alias_addr,
  input  logic [$clog2(DATA_W)-1:0] alias_bit,
  output logic                      up_ready,
  output logic [DATA_W-1:0]         up_rdata,
  output logic                      dn_valid,
  input  logic                      dn_ready,
  output logic [ADDR_W-1:0]         dn_addr,
  output logic                      dn_write,
  output logic [1:0]                dn_size,
  output logic [DATA_W-1:0]         dn_wdata,
  input  logic [DATA_W-1:0]         dn_rdata,
  output logic                      dn_lock
);
  localparam int BIT_W = $clog2(DATA_W);

  seq_state_e st_q, st_d;

  logic              cap_en, old_en, rsp_en;
  logic              cap_alias_q, cap_write_q;
  logic [ADDR_W-1:0] cap_addr_q,  cap_addr_d;
  logic [1:0]        cap_size_q,  cap_size_d;
  logic [DATA_W-1:0] cap_wdata_q;
  logic [BIT_W-1:0]  cap_bit_q;
  logic [DATA_W-1:0] old_q;
  logic [DATA_W-1:0] rsp_q, rsp_d;
  logic [DATA_W-1:0] merged;
  logic              dn_hs;

  assign dn_hs      = dn_valid && dn_ready;
  assign cap_addr_d = alias_hit ? alias_addr : up_addr;
  assign cap_size_d = alias_hit ? SIZE_WORD  : up_size;

  always_comb begin
    merged            = old_q;
    merged[cap_bit_q] = cap_wdata_q[0];
  end

  // next-state and output decode
  always_comb begin
    st_d     = st_q;
    cap_en   = 1'b0;
    old_en   = 1'b0;
    rsp_en   = 1'b0;
    rsp_d    = '0;
    dn_valid = 1'b0;
    dn_write = 1'b0;
    dn_addr  = cap_addr_q;
    dn_size  = cap_size_q;
    dn_wdata = cap_wdata_q;
    dn_lock  = 1'b0;
    up_ready = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (up_valid) begin
          cap_en = 1'b1;
          if (!alias_hit)    st_d = ST_PASS;
          else if (up_write) st_d = ST_RMW_RD;
          else               st_d = ST_ALRD;
        end
      end
      ST_PASS: begin
        dn_valid = 1'b1;
        dn_write = cap_write_q;
        if (dn_ready) begin
          rsp_en = 1'b1;
          rsp_d  = cap_write_q ? '0 : dn_rdata;
          st_d   = ST_RESP;
        end
      end
      ST_ALRD: begin
        dn_valid = 1'b1;
        if (dn_ready) begin
          rsp_en = 1'b1;
          rsp_d  = {{(DATA_W-1){1'b0}}, dn_rdata[cap_bit_q]};
          st_d   = ST_RESP;
        end
      end
      ST_RMW_RD: begin
        dn_valid = 1'b1;
        dn_lock  = 1'b1;
        if (dn_ready) begin
          old_en = 1'b1;
          st_d   = ST_RMW_WR;
        end
      end
      ST_RMW_WR: begin
        dn_valid = 1'b1;
        dn_write = 1'b1;
        dn_wdata = merged;
        dn_lock  = 1'b1;
        if (dn_ready) begin
          rsp_en = 1'b1;
          st_d   = ST_RESP;
        end
      end
      ST_RESP: begin
        up_ready = 1'b1;
        st_d     = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_alias_q <= 1'b0;
      cap_write_q <= 1'b0;
      cap_addr_q  <= '0;
      cap_size_q  <= '0;
      cap_wdata_q <= '0;
      cap_bit_q   <= '0;
    end else if (cap_en) begin
      cap_alias_q <= alias_hit;
      cap_write_q <= up_write;
      cap_addr_q  <= cap_addr_d;
      cap_size_q  <= cap_size_d;
      cap_wdata_q <= up_wdata;
      cap_bit_q   <= alias_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      old_q <= '0;
    else if (old_en) old_q <= dn_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rsp_q <= '0;
    else if (rsp_en) rsp_q <= rsp_d;
  end

  assign up_rdata = rsp_q;

  // R5
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_lock && !(dn_hs && dn_write) |=> dn_lock);
  // R5
  lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_lock && dn_hs && dn_write |=> !dn_lock);
  // R5
  lock_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_ready |-> !dn_lock);
  // R7
  rdy_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_ready |=> !up_ready);
  // R7
  dn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_addr) && $stable(dn_write) && $stable(dn_wdata));
  // R2
  rsp_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_ready && cap_alias_q && !cap_write_q |-> up_rdata[DATA_W-1:1] == '0);
  // R3
  one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && dn_write && dn_lock |-> $countones(dn_wdata ^ old_q) <= 1);
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge #(
  parameter int ADDR_W      = bb_pkg::ADDR_W_DEF,
  parameter int DATA_W      = bb_pkg::DATA_W_DEF,
  parameter int NUM_WIN     = bb_pkg::NUM_WIN_DEF,
  parameter int REGION_LOG2 = bb_pkg::REGION_LOG2_DEF,
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] REGION_BASE = bb_pkg::REGION_BASE_DEF,
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] ALIAS_BASE  = bb_pkg::ALIAS_BASE_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic              up_write,
  input  logic [1:0]        up_size,
  input  logic [DATA_W-1:0] up_wdata,
  output logic [DATA_W-1:0] up_rdata,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [ADDR_W-1:0] dn_addr,
  output logic              dn_write,
  output logic [1:0]        dn_size,
  output logic [DATA_W-1:0] dn_wdata,
  input  logic [DATA_W-1:0] dn_rdata,
  output logic              dn_lock
);
  localparam int BIT_W = $clog2(DATA_W);

  logic              rst_n_sync;
  logic              alias_hit;
  logic [ADDR_W-1:0] alias_addr;
  logic [BIT_W-1:0]  alias_bit;

  bb_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_sync)
  );

  bb_decode #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .NUM_WIN     (NUM_WIN),
    .REGION_LOG2 (REGION_LOG2),
    .REGION_BASE (REGION_BASE),
    .ALIAS_BASE  (ALIAS_BASE)
  ) u_dec (
    .addr      (up_addr),
    .alias_hit (alias_hit),
    .word_addr (alias_addr),
    .bit_idx   (alias_bit)
  );

  bb_seq #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .up_valid   (up_valid),
    .up_addr    (up_addr),
    .up_write   (up_write),
    .up_size    (up_size),
    .up_wdata   (up_wdata),
    .alias_hit  (alias_hit),
    .alias_addr (alias_addr),
    .alias_bit  (alias_bit),
    .up_ready   (up_ready),
    .up_rdata   (up_rdata),
    .dn_valid   (dn_valid),
    .dn_ready   (dn_ready),
    .dn_addr    (dn_addr),
    .dn_write   (dn_write),
    .dn_size    (dn_size),
    .dn_wdata   (dn_wdata),
    .dn_rdata   (dn_rdata),
    .dn_lock    (dn_lock)
  );
endmodule

// File: tb/bitband_bridge_tb.sv
`timescale 1ns/1ps
module bitband_bridge_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        up_valid = 1'b0;
  logic        up_ready;
  logic [31:0] up_addr = '0;
  logic        up_write = 1'b0;
  logic [1:0]  up_size = 2'd2;
  logic [31:0] up_wdata = '0;
  logic [31:0] up_rdata;
  logic        dn_valid;
  logic        dn_ready;
  logic [31:0] dn_addr;
  logic        dn_write;
  logic [1:0]  dn_size;
  logic [31:0] dn_wdata;
  logic [31:0] dn_rdata;
  logic        dn_lock;

  always #2.5 clk = ~clk;

  bitband_bridge u_dut (
    .clk(clk), .rst_n(rst_n),
    .up_valid(up_valid), .up_ready(up_ready), .up_addr(up_addr), .up_write(up_write),
    .up_size(up_size), .up_wdata(up_wdata), .up_rdata(up_rdata),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_addr(dn_addr), .dn_write(dn_write),
    .dn_size(dn_size), .dn_wdata(dn_wdata), .dn_rdata(dn_rdata), .dn_lock(dn_lock)
  );

  int n_chk  = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // memory model behind the downstream port
  logic [31:0] mem [512];
  logic [1:0]  stall_cnt = 2'd0;

  function automatic int mkey(input logic [31:0] a);
    return int'({a[30], a[9:2]});
  endfunction

  assign dn_ready = (stall_cnt != 2'd0);
  assign dn_rdata = mem[mkey(dn_addr)];

  always @(posedge clk) begin
    stall_cnt <= stall_cnt + 2'd1;
    if (!rst_n) begin
      for (int i = 0; i < 512; i++) mem[i] <= '0;
    end else if (dn_valid && dn_ready && dn_write) begin
      mem[mkey(dn_addr)] <= dn_wdata;
    end
  end

  // downstream handshake log: {addr, write, size, wdata, lock}
  typedef struct packed {
    logic [31:0] addr;
    logic        wr;
    logic [1:0]  sz;
    logic [31:0] wd;
    logic        lk;
  } hs_t;
  hs_t hs_q[$];

  always @(posedge clk) begin
    if (rst_n && dn_valid && dn_ready)
      hs_q.push_back({dn_addr, dn_write, dn_size, dn_wdata, dn_lock});
  end

  // scoreboard
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always @(negedge clk) begin
    if (rst_n && up_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 completion without request", up_rdata, 32'h0);
      end else begin
        logic [31:0] e;
        string       t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(up_rdata == e, t, up_rdata, e);
        chk(!dn_lock, "R5 lock low at completion", {31'b0, dn_lock}, 32'h0);
      end
    end
  end

  function automatic logic [31:0] alias_of(input logic [31:0] abase, input logic [31:0] rbase,
                                           input logic [31:0] waddr, input int n);
    return abase + (waddr - rbase) * 32 + n * 4;
  endfunction

  task automatic tx(input logic [31:0] a, input bit wr, input logic [1:0] sz, input logic [31:0] wd,
                    input logic [31:0] exp_rd, input string tag, input int exp_hs,
                    input logic [31:0] exp_dn_addr, input logic [1:0] exp_dn_sz);
    @(negedge clk);
    hs_q.delete();
    exp_q.push_back(exp_rd);
    tag_q.push_back(tag);
    up_valid = 1'b1;
    up_addr  = a;
    up_write = wr;
    up_size  = sz;
    up_wdata = wd;
    do @(negedge clk); while (!up_ready);
    up_valid = 1'b0;
    chk(hs_q.size() == exp_hs, {tag, " transfer count"}, 32'(hs_q.size()), 32'(exp_hs));
    if (hs_q.size() >= 1) begin
      chk(hs_q[0].addr == exp_dn_addr, {tag, " downstream address"}, hs_q[0].addr, exp_dn_addr);
      chk(hs_q[0].sz == exp_dn_sz, {tag, " downstream size"}, 32'(hs_q[0].sz), 32'(exp_dn_sz));
    end
    if (exp_hs == 2 && hs_q.size() == 2) begin
      // R5: read then write, same word, both locked
      chk(hs_q[0].lk && hs_q[1].lk && !hs_q[0].wr && hs_q[1].wr && hs_q[1].addr == exp_dn_addr,
          "R5 locked read then write", {28'b0, hs_q[0].lk, hs_q[1].lk, hs_q[0].wr, hs_q[1].wr}, 32'hD);
    end
    if (exp_hs == 1 && hs_q.size() == 1) begin
      chk(!hs_q[0].lk && hs_q[0].wr == wr, "R6 single unlocked transfer",
          {30'b0, hs_q[0].lk, hs_q[0].wr}, {30'b0, 1'b0, wr});
      if (wr) chk(hs_q[0].wd == wd, "R6 write data unchanged", hs_q[0].wd, wd);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  localparam logic [31:0] R0 = 32'h2000_0000;
  localparam logic [31:0] R1B = 32'h4000_0000;
  localparam logic [31:0] W0 = 32'h2200_0000;
  localparam logic [31:0] W1 = 32'h4200_0000;
  localparam logic [31:0] A0 = 32'h2000_0010;
  localparam logic [31:0] B0 = 32'h4000_0020;
  localparam logic [31:0] AT = 32'h200F_FFFC;

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(!up_ready, "R8 up_ready in reset", {31'b0, up_ready}, 32'h0);
    chk(!dn_valid, "R8 dn_valid in reset", {31'b0, dn_valid}, 32'h0);
    chk(!dn_lock,  "R8 dn_lock in reset",  {31'b0, dn_lock},  32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R6 plain accesses inside region 0
    tx(A0, 1, 2'd2, 32'hA5A5_0F0F, 32'h0, "R6 region write", 1, A0, 2'd2);
    tx(A0, 0, 2'd2, 32'h0, 32'hA5A5_0F0F, "R6 region read", 1, A0, 2'd2);

    // R1 R2 alias reads
    tx(alias_of(W0, R0, A0, 0),  0, 2'd2, 32'h0, 32'h1, "R2 alias read bit0",  1, A0, 2'd2);
    tx(alias_of(W0, R0, A0, 4),  0, 2'd2, 32'h0, 32'h0, "R2 alias read bit4",  1, A0, 2'd2);
    tx(alias_of(W0, R0, A0, 31), 0, 2'd2, 32'hFFFF_FFFF, 32'h1, "R1 alias read bit31", 1, A0, 2'd2);

    // R3 alias writes
    tx(alias_of(W0, R0, A0, 4), 1, 2'd2, 32'hFFFF_FFF1, 32'h0, "R3 alias set bit4", 2, A0, 2'd2);
    chk(mem[mkey(A0)] == 32'hA5A5_0F1F, "R3 set bit4 word", mem[mkey(A0)], 32'hA5A5_0F1F);
    tx(alias_of(W0, R0, A0, 31), 1, 2'd2, 32'hFFFF_FFFE, 32'h0, "R3 alias clear bit31", 2, A0, 2'd2);
    chk(mem[mkey(A0)] == 32'h25A5_0F1F, "R3 clear bit31 word", mem[mkey(A0)], 32'h25A5_0F1F);

    // R4 sizes and low address bits ignored
    tx(alias_of(W0, R0, A0, 4) + 3, 0, 2'd0, 32'h0, 32'h1, "R4 byte alias read", 1, A0, 2'd2);
    tx(alias_of(W0, R0, A0, 4) + 2, 0, 2'd1, 32'h0, 32'h1, "R4 half alias read", 1, A0, 2'd2);
    tx(alias_of(W0, R0, A0, 31) + 1, 0, 2'd0, 32'h0, 32'h0, "R4 byte alias read bit31", 1, A0, 2'd2);
    tx(alias_of(W0, R0, A0, 12) + 1, 1, 2'd0, 32'h0000_0001, 32'h0, "R4 byte alias set", 2, A0, 2'd2);
    chk(mem[mkey(A0)] == 32'h25A5_1F1F, "R4 byte set word", mem[mkey(A0)], 32'h25A5_1F1F);
    tx(alias_of(W0, R0, A0, 0) + 2, 1, 2'd1, 32'h0000_0002, 32'h0, "R4 half alias clear", 2, A0, 2'd2);
    tx(A0, 0, 2'd2, 32'h0, 32'h25A5_1F1E, "R3 other bits kept", 1, A0, 2'd2);

    // R9 second window acts on second region
    tx(B0, 1, 2'd2, 32'h0, 32'h0, "R9 region1 write", 1, B0, 2'd2);
    tx(alias_of(W1, R1B, B0, 7), 1, 2'd0, 32'h1, 32'h0, "R9 alias set bit7", 2, B0, 2'd2);
    chk(mem[mkey(B0)] == 32'h0000_0080, "R9 region1 word", mem[mkey(B0)], 32'h0000_0080);
    tx(alias_of(W1, R1B, B0, 7), 0, 2'd2, 32'h0, 32'h1, "R9 alias read bit7", 1, B0, 2'd2);
    tx(alias_of(W1, R1B, B0, 6), 0, 2'd2, 32'h0, 32'h0, "R9 alias read bit6", 1, B0, 2'd2);
    tx(B0, 0, 2'd2, 32'h0, 32'h0000_0080, "R9 region1 read", 1, B0, 2'd2);
    chk(mem[mkey(A0)] == 32'h25A5_1F1E, "R9 region0 untouched", mem[mkey(A0)], 32'h25A5_1F1E);

    // R6 outside both windows
    tx(32'h1000_0040, 1, 2'd0, 32'h1234_5678, 32'h0, "R6 outside byte write", 1, 32'h1000_0040, 2'd0);
    tx(32'h1000_0040, 0, 2'd1, 32'h0, 32'h1234_5678, "R6 outside read", 1, 32'h1000_0040, 2'd1);
    tx(32'h2100_0000, 1, 2'd2, 32'hCAFE_0001, 32'h0, "R6 gap write", 1, 32'h2100_0000, 2'd2);
    tx(32'h2100_0000, 0, 2'd2, 32'h0, 32'hCAFE_0001, "R6 gap read", 1, 32'h2100_0000, 2'd2);

    // R1 last alias word of window 0
    tx(32'h23FF_FFFC, 0, 2'd2, 32'h0, 32'h0, "R1 top alias read", 1, AT, 2'd2);
    tx(32'h23FF_FFFC, 1, 2'd2, 32'h1, 32'h0, "R1 top alias set", 2, AT, 2'd2);
    chk(mem[mkey(AT)] == 32'h8000_0000, "R1 top word bit31", mem[mkey(AT)], 32'h8000_0000);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R7 one completion per request", 32'(exp_q.size()), 32'h0);
    finish_run();
  end
endmodule